// File: doc/BRIEF.md
# Stack Pointer Literal Adjust Unit

This execution unit owns a 14-bit software-stack pointer and carries out three single-word operations on it. Two of them move the pointer by a 6-bit unsigned literal, one upward and one downward, and then return from the current subroutine. The third stores an 8-bit literal in data memory at the address the pointer holds, and then steps the pointer down by one. The unit takes a 16-bit instruction word with a valid strobe, together with the return address now at the top of the hardware return stack.

For an adjust-and-return operation, the unit updates the pointer and, for one cycle, raises a PC load carrying the top-of-stack address, a return-stack pop request and a pipeline flush. The word fetched behind the return is dropped in that cycle, so each of these operations occupies two cycles. A literal push completes in one cycle. It drives a registered data-memory write and updates the pointer at the same clock edge. None of the three operations changes a status flag. An opcode the unit does not recognise leaves every output unchanged.

Top module: `sp_adjust_unit`

## Requirements
- R1: While rst_n is low, sp_value is SP_RESET (0 by default), and mem_we, pc_load, ret_pop and flush are all 0.
- R2: An accepted word whose upper ten bits are 1110100011 (hex E8 followed by bits 7:6 = 11) sets sp_value to sp_value plus the literal in bits 5:0, modulo 2^14. The new value is visible in the cycle after the accepting edge.
- R3: An accepted word whose upper ten bits are 1110100111 (hex E9 followed by bits 7:6 = 11) sets sp_value to sp_value minus the literal in bits 5:0, modulo 2^14.
- R4: An accepted word whose upper byte is hex FA raises mem_we for exactly one cycle, with mem_addr equal to the pointer before the edge and mem_wdata equal to bits 7:0. In that same cycle sp_value reads one less than the old pointer.
- R5: After an accepted R2 or R3 word, pc_load, ret_pop and flush are all high for exactly one cycle, and pc_target equals the tos_addr sampled at the accepting edge.
- R6: A word presented while flush is high is discarded. It changes neither the pointer nor the memory, and it raises no PC load.
- R7: A cycle with instr_valid low, or with an unrecognised opcode (including E8 or E9 with bits 7:6 not equal to 11), changes no output.
- R8: A push never raises pc_load, ret_pop or flush, and an adjust-and-return never raises mem_we.
- R9: The pointer wraps modulo 16384. Adding past 3FFF continues from 0, and subtracting or pushing below 0 continues from 3FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | instr_word holds a word for this unit |
| instr_word | input | 16 | Instruction word |
| tos_addr | input | PC_W | Return address at the top of the return stack |
| sp_value | output | SP_W | Current stack pointer |
| mem_we | output | 1 | Data-memory write strobe |
| mem_addr | output | SP_W | Data-memory write address |
| mem_wdata | output | 8 | Data-memory write data |
| pc_load | output | 1 | Load the PC from pc_target |
| pc_target | output | PC_W | Return address to load |
| ret_pop | output | 1 | Pop request to the return stack |
| flush | output | 1 | Discard the word fetched behind the return |

## Verification
Each pointer operation exposes its result on sp_value in the very next cycle, so a wrong adder, a wrong literal slice or a missed wrap appears one cycle after the word is accepted. A push also exposes the old pointer on mem_addr, which makes an error in the decrement order visible in that same cycle. If the flush-slot state is wrong, the dropped word either moves the pointer or fires a second PC load one cycle after the return pulse. If the state sticks high, every later word is lost, and the next pointer check shows it.

// File: rtl/sp_adjust_pkg.sv
// Shared types and opcode constants for the stack pointer adjust unit.
package sp_adjust_pkg;
    // Decoded operation selected by the current instruction word.
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_PUSH = 2'd3
    } sp_op_e;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned LIT_W  = 8;
    localparam int unsigned ADJ_W  = 6;

    localparam logic [7:0] HI_ADD  = 8'hE8;
    localparam logic [7:0] HI_SUB  = 8'hE9;
    localparam logic [7:0] HI_PUSH = 8'hFA;
    localparam logic [1:0] RET_TAG = 2'b11;

    // One issued command: the operation and its zero-extended literal.
    typedef struct packed {
        sp_op_e             op;
        logic [LIT_W-1:0]   lit;
    } sp_cmd_t;
endpackage

// File: rtl/sp_adj_decode.sv
// Opcode decoder. It turns a valid instruction word into a command, and it
// issues nothing while the flush slot is active or the word is unknown.
// Assumes: slot_busy is a registered signal, so no combinational loop forms.
module sp_adj_decode
    import sp_adjust_pkg::*;
(
    input  logic              instr_valid,
    input  logic              slot_busy,
    input  logic [WORD_W-1:0] instr_word,
    output sp_cmd_t           cmd
);
    logic [7:0] hi_byte;
    logic       ret_ok;

    assign hi_byte = instr_word[WORD_W-1:WORD_W-8];
    assign ret_ok  = (instr_word[7:6] == RET_TAG);

    // Purpose: classify the word and pick out its literal.
    always_comb begin
        cmd.op  = OP_NONE;
        cmd.lit = instr_word[LIT_W-1:0];
        if (instr_valid && !slot_busy) begin
            if (hi_byte == HI_ADD && ret_ok) begin
                cmd.op  = OP_ADD;
                cmd.lit = {{(LIT_W-ADJ_W){1'b0}}, instr_word[ADJ_W-1:0]};
            end else if (hi_byte == HI_SUB && ret_ok) begin
                cmd.op  = OP_SUB;
                cmd.lit = {{(LIT_W-ADJ_W){1'b0}}, instr_word[ADJ_W-1:0]};
            end else if (hi_byte == HI_PUSH) begin
                cmd.op  = OP_PUSH;
            end
        end
    end
endmodule

// File: rtl/sp_adj_pointer.sv
// Stack pointer register and data-memory write port. Add and subtract move
// the pointer by the literal. Push writes the literal at the old pointer
// and post-decrements the pointer in the same cycle. All arithmetic wraps
// modulo 2**SP_W. Assumes: cmd is already gated by the flush slot.
module sp_adj_pointer
    import sp_adjust_pkg::*;
#(
    parameter int unsigned   SP_W     = 14,
    parameter logic [SP_W-1:0] SP_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sp_cmd_t          cmd,
    output logic [SP_W-1:0]  sp_q,
    output logic             we_q,
    output logic [SP_W-1:0]  addr_q,
    output logic [LIT_W-1:0] wdata_q
);
    localparam logic [SP_W-1:0] ONE = SP_W'(1);

    logic [SP_W-1:0] lit_ext;
    logic [SP_W-1:0] sp_d;

    assign lit_ext = SP_W'(cmd.lit);

    // Purpose: compute the next pointer value for the issued command.
    always_comb begin
        unique case (cmd.op)
            OP_ADD:  sp_d = sp_q + lit_ext;
            OP_SUB:  sp_d = sp_q - lit_ext;
            OP_PUSH: sp_d = sp_q - ONE;
            default: sp_d = sp_q;
        endcase
    end

    // Purpose: hold the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= SP_RESET;
        else        sp_q <= sp_d;
    end

    // Purpose: register the one-cycle write strobe and its address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            we_q <= (cmd.op == OP_PUSH);
            if (cmd.op == OP_PUSH) begin
                addr_q  <= sp_q;
                wdata_q <= cmd.lit;
            end
        end
    end
endmodule

// File: rtl/sp_adj_retseq.sv
// Return sequencer. After an adjust-and-return it holds one flushed cycle,
// in which it raises PC load, return-stack pop and flush, and captures the
// top-of-stack address. Assumes: the decoder blocks issue while slot_q is
// high, so the slot never lasts more than one cycle.
module sp_adj_retseq
    import sp_adjust_pkg::*;
#(
    parameter int unsigned PC_W = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  sp_cmd_t         cmd,
    input  logic [PC_W-1:0] tos_addr,
    output logic            slot_q,
    output logic [PC_W-1:0] target_q
);
    logic is_ret;

    assign is_ret = (cmd.op == OP_ADD) || (cmd.op == OP_SUB);

    // Purpose: open the flushed slot for one cycle after a return.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= 1'b0;
        else        slot_q <= is_ret;
    end

    // Purpose: latch the return address at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      target_q <= '0;
        else if (is_ret) target_q <= tos_addr;
    end
endmodule

// File: rtl/sp_adjust_unit.sv
// Top of the stack pointer literal adjust unit. It wires the decoder, the
// pointer datapath and the return sequencer together. Assumes: the fetch
// stage honours flush by squashing the word it presents in the slot cycle.
module sp_adjust_unit
    import sp_adjust_pkg::*;
#(
    parameter int unsigned     SP_W     = 14,
    parameter int unsigned     PC_W     = 21,
    parameter logic [SP_W-1:0] SP_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [15:0]      instr_word,
    input  logic [PC_W-1:0]  tos_addr,
    output logic [SP_W-1:0]  sp_value,
    output logic             mem_we,
    output logic [SP_W-1:0]  mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_target,
    output logic             ret_pop,
    output logic             flush
);
    sp_cmd_t cmd;
    logic    slot;

    sp_adj_decode u_dec (
        .instr_valid (instr_valid),
        .slot_busy   (slot),
        .instr_word  (instr_word),
        .cmd         (cmd)
    );

    sp_adj_pointer #(.SP_W(SP_W), .SP_RESET(SP_RESET)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .sp_q    (sp_value),
        .we_q    (mem_we),
        .addr_q  (mem_addr),
        .wdata_q (mem_wdata)
    );

    sp_adj_retseq #(.PC_W(PC_W)) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .tos_addr (tos_addr),
        .slot_q   (slot),
        .target_q (pc_target)
    );

    assign pc_load = slot;
    assign ret_pop = slot;
    assign flush   = slot;
endmodule

// File: rtl/sp_adjust_chk.sv
// Property checker for sp_adjust_unit. It observes the ports only and is
// attached to every instance through the bind below.
module sp_adjust_chk #(
    parameter int unsigned SP_W = 14,
    parameter int unsigned PC_W = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic [15:0]     instr_word,
    input logic [PC_W-1:0] tos_addr,
    input logic [SP_W-1:0] sp_value,
    input logic            mem_we,
    input logic [SP_W-1:0] mem_addr,
    input logic [7:0]      mem_wdata,
    input logic            pc_load,
    input logic [PC_W-1:0] pc_target,
    input logic            ret_pop,
    input logic            flush
);
    logic acc_add, acc_sub, acc_push;

    assign acc_add  = instr_valid && !flush && instr_word[15:6] == 10'b1110100011;
    assign acc_sub  = instr_valid && !flush && instr_word[15:6] == 10'b1110100111;
    assign acc_push = instr_valid && !flush && instr_word[15:8] == 8'hFA;

    p_add_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_add |=> sp_value == SP_W'($past(sp_value) + SP_W'($past(instr_word[5:0]))));

    p_sub_diff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sub |=> sp_value == SP_W'($past(sp_value) - SP_W'($past(instr_word[5:0]))));

    p_push_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_push |=> mem_we && mem_addr == $past(sp_value) && mem_wdata == $past(instr_word[7:0]));

    p_push_postdec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sp_value == SP_W'(mem_addr - SP_W'(1)));

    p_ret_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_add || acc_sub) |=> pc_load && ret_pop && flush && pc_target == $past(tos_addr));

    p_flush_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    p_slot_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $stable(sp_value) && !mem_we && !pc_load);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(sp_value) && !mem_we && !pc_load);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !pc_load && !ret_pop && !flush);
endmodule

bind sp_adjust_unit sp_adjust_chk #(.SP_W(SP_W), .PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .tos_addr    (tos_addr),
    .sp_value    (sp_value),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .pc_load     (pc_load),
    .pc_target   (pc_target),
    .ret_pop     (ret_pop),
    .flush       (flush)
);

// File: tb/sp_adjust_unit_test.sv
`timescale 1ns/1ps
module sp_adjust_unit_test;
    localparam int SP_W = 14;
    localparam int PC_W = 21;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            instr_valid = 1'b0;
    logic [15:0]     instr_word = '0;
    logic [PC_W-1:0] tos_addr = '0;
    logic [SP_W-1:0] sp_value;
    logic            mem_we;
    logic [SP_W-1:0] mem_addr;
    logic [7:0]      mem_wdata;
    logic            pc_load;
    logic [PC_W-1:0] pc_target;
    logic            ret_pop;
    logic            flush;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic [SP_W-1:0] m_sp;
    bit  m_slot;

    sp_adjust_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .tos_addr(tos_addr), .sp_value(sp_value), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_target(pc_target),
        .ret_pop(ret_pop), .flush(flush)
    );

    always #4 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // 0 unknown, 1 add-return, 2 sub-return, 3 push
    function automatic int classify(logic [15:0] w);
        if (w[15:6] == 10'b1110100011) return 1;
        if (w[15:6] == 10'b1110100111) return 2;
        if (w[15:8] == 8'hFA)          return 3;
        return 0;
    endfunction

    function automatic logic [15:0] mk_add(int k);  return {8'hE8, 2'b11, 6'(k)}; endfunction
    function automatic logic [15:0] mk_sub(int k);  return {8'hE9, 2'b11, 6'(k)}; endfunction
    function automatic logic [15:0] mk_push(int k); return {8'hFA, 8'(k)}; endfunction

    // Drive one word at a falling edge, then check the outputs at the next falling edge.
    task automatic step(bit v, logic [15:0] w, logic [PC_W-1:0] t);
        int   c   = classify(w);
        bit   acc = v && !m_slot;
        int   k   = (c == 3) ? int'(w[7:0]) : int'(w[5:0]);
        int   raw = int'(m_sp);
        bit   wrap = 0;
        logic [SP_W-1:0] e_sp = m_sp;
        string tg;
        if (acc && c == 1) begin raw = raw + k; wrap = raw > 16383; end
        if (acc && c == 2) begin raw = raw - k; wrap = raw < 0; end
        if (acc && c == 3) begin raw = raw - 1; wrap = raw < 0; end
        e_sp = SP_W'(raw);
        if (!acc)        tg = v ? "R6" : "R7";
        else if (c == 1) tg = "R2";
        else if (c == 2) tg = "R3";
        else if (c == 3) tg = "R4";
        else             tg = "R7";
        if (!m_slot && v && c == 0) tg = "R7";
        instr_valid = v; instr_word = w; tos_addr = t;
        @(posedge clk);
        @(negedge clk);
        check(wrap ? "R9" : tg, 32'(sp_value), 32'(e_sp));
        check((acc && (c == 1 || c == 2)) ? "R8" : tg, 32'(mem_we), 32'(acc && c == 3));
        if (acc && c == 3) begin
            check("R4", 32'(mem_addr), 32'(m_sp));
            check("R4", 32'(mem_wdata), 32'(k));
        end
        check((acc && c == 3) ? "R8" : ((acc && c != 0) ? "R5" : tg),
              32'(pc_load), 32'(acc && (c == 1 || c == 2)));
        check("R5", 32'(ret_pop), 32'(acc && (c == 1 || c == 2)));
        check("R5", 32'(flush), 32'(acc && (c == 1 || c == 2)));
        if (acc && (c == 1 || c == 2)) check("R5", 32'(pc_target), 32'(t));
        m_sp   = e_sp;
        m_slot = acc && (c == 1 || c == 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val = $urandom(32'h5EED_0042);
        m_sp = '0; m_slot = 0;
        repeat (3) @(negedge clk);
        check("R1", 32'(sp_value), 32'h0);
        check("R1", 32'(mem_we), 32'h0);
        check("R1", 32'(pc_load), 32'h0);
        check("R1", 32'(ret_pop), 32'h0);
        check("R1", 32'(flush), 32'h0);
        rst_n = 1'b1;

        // R9: push at zero wraps down, add wraps back up
        step(1, mk_push(8'h5A), 21'h0);
        step(1, mk_add(1), 21'h1234);
        step(0, 16'h0, 21'h0);
        // climb to 03FF, then the worked values for R2 and R3
        for (int i = 0; i < 16; i++) begin
            step(1, mk_add(63), 21'(i));
            step(0, 16'h0, 21'h0);
        end
        step(1, mk_add(15), 21'h77);
        step(0, 16'h0, 21'h0);
        step(1, mk_add(8'h23), 21'h00100);
        step(0, 16'h0, 21'h0);
        step(1, mk_sub(8'h23), 21'h1ABCD);
        step(0, 16'h0, 21'h0);
        step(1, mk_sub(8'h23), 21'h00200);
        step(0, 16'h0, 21'h0);
        // move down to 01EC and push 08 (R4)
        for (int i = 0; i < 7; i++) begin
            step(1, mk_sub(63), 21'h5);
            step(0, 16'h0, 21'h0);
        end
        step(1, mk_sub(55), 21'h6);
        step(0, 16'h0, 21'h0);
        step(1, mk_push(8'h08), 21'h0);
        step(1, mk_push(8'hFF), 21'h0);
        // R6: a word in the slot is dropped, even a push
        step(1, mk_add(10), 21'h3);
        step(1, mk_push(8'h11), 21'h4);
        step(1, mk_sub(5), 21'h9);
        step(1, mk_add(40), 21'hA);
        // R7: near-miss encodings
        step(1, 16'hE825, 21'h0);
        step(1, 16'hE9A5, 21'h0);
        step(1, 16'hFB12, 21'h0);
        step(0, mk_push(8'h33), 21'h0);
        // R3 with R9: subtract below zero
        step(1, mk_sub(63), 21'h0);
        for (int i = 0; i < 40; i++) begin
            step(1, mk_sub(63), 21'(i));
        end
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int sel = int'($urandom_range(0, 9));
            logic [15:0] w;
            logic [PC_W-1:0] t = PC_W'($urandom);
            bit v = 1;
            case (sel)
                0, 1:    w = mk_add(int'($urandom_range(0, 63)));
                2, 3:    w = mk_sub(int'($urandom_range(0, 63)));
                4, 5, 6: w = mk_push(int'($urandom_range(0, 255)));
                7:       w = {8'hE8 | 8'(($urandom & 1)), 2'(($urandom_range(0, 2))), 6'($urandom)};
                8:       w = 16'($urandom);
                default: begin w = 16'($urandom); v = 0; end
            endcase
            step(v, w, t);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule